// File: doc/BRIEF.md
# Packed Vector Rounding Right Shifter

This block shifts each lane of a 64-bit packed operand word to the right and rounds the result. A 2-bit width code splits the word into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. The shift count for each lane comes from one of three places: the matching lane of a second vector, a scalar shared by every lane, or a 5-bit immediate taken from the instruction word. The shift fills with zeros or with copies of the sign bit, depending on the function code.

After the shift, a 0 or 1 increment is added. A 2-bit rounding-mode input picks this increment from the bits that the shift discards. The sum is cut back to the lane width, with no saturation. A per-lane mask chooses which lanes take the new value and which keep the old destination contents.

The unit decodes a 32-bit instruction word. It registers its result, so the result appears one clock after the operands are accepted. Sequencing over a vector length and register-file access belong to the surrounding pipeline.

Top module: `vscale_shift`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` goes to 0 and `result` goes to all zeros on that edge.
- R2: `sew` selects the lane width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. Lane i occupies `result[i*W +: W]` and is controlled by `mask[i]`.
- R3: Only the low log2(W) bits of a shift count are used (3, 4, 5 or 6 bits). All higher bits have no effect.
- R4: Function code `instr[31:26]` = 101010 shifts with zero fill. Function code 101011 shifts with sign fill, treating each lane as signed.
- R5: `instr[14:12]` picks the count source: 000 takes the matching lane of `vs1_data`, 100 takes `scalar`, 011 takes the immediate in `instr[19:15]`.
- R6: The immediate is zero-extended for the zero-fill shift and sign-extended for the sign-fill shift. The difference shows in 64-bit lanes when `instr[19]` is 1.
- R7: Let d be the most significant discarded bit and L the lowest bit of the shifted value. `rnd_mode` 00 adds d. Mode 01 adds d when any lower discarded bit is set or L is 1. Mode 10 adds 0. Mode 11 adds 1 when L is 0 and any discarded bit is set.
- R8: A lane whose effective shift count is 0 returns its operand unchanged, in every rounding mode.
- R9: A carry out of the rounding add wraps within the lane and does not reach the neighbouring lane.
- R10: When `instr[25]` is 1, every lane is written. When it is 0, a lane whose mask bit is 0 takes its value from `old_dest`.
- R11: An instruction is accepted only when `instr[6:0]` = 1010111, the function code is one of the two above, and the source code is one of the three above. When `in_valid` is high but the instruction is not accepted, `out_valid` drops and `result` holds its value.
- R12: An accepted instruction produces its result and `out_valid` = 1 on the next clock edge. A cycle without an accepted instruction clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and instruction are present |
| instr | input | 32 | Instruction word |
| sew | input | 2 | Lane width code |
| rnd_mode | input | 2 | Rounding mode |
| vs2_data | input | 64 | Operand word to be shifted |
| vs1_data | input | 64 | Per-lane shift counts |
| scalar | input | 64 | Shared shift count |
| mask | input | 8 | Per-lane write enables |
| old_dest | input | 64 | Prior destination word |
| out_valid | output | 1 | Result is valid |
| result | output | 64 | Registered shifted and rounded word |

## Verification
Byte lanes with discarded patterns 100 and 100 over an odd or even kept value tell the four rounding modes apart. All-ones bytes shifted by one expose the difference between zero fill and sign fill, and the wrap of the rounding carry. A 64-bit lane with immediate 10000 can only come out right if the immediate is extended correctly for each shift kind. Scalars and vector counts with high bits set show that those bits are masked. Random operands over every width, mode and source, with counts forced to 0 and W-1, are compared lane by lane against an independent model.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam logic [6:0] MAJOR_OP = 7'b1010111;
  localparam logic [5:0] FN_LOGIC = 6'b101010;
  localparam logic [5:0] FN_ARITH = 6'b101011;
  localparam logic [2:0] SRC_VV   = 3'b000;
  localparam logic [2:0] SRC_VX   = 3'b100;
  localparam logic [2:0] SRC_VI   = 3'b011;

  typedef enum logic [1:0] {
    RM_HALF_UP = 2'b00,
    RM_EVEN    = 2'b01,
    RM_TRUNC   = 2'b10,
    RM_ODD     = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    CNT_VEC = 2'd0,
    CNT_SCL = 2'd1,
    CNT_IMM = 2'd2
  } cnt_src_e;
endpackage

// File: rtl/vss_decode.sv
module vss_decode
  import vss_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [31:0]     instr,
  output logic            legal,
  output logic            arith,
  output logic            unmasked,
  output cnt_src_e        src,
  output logic [XLEN-1:0] imm_ext
);
  logic [5:0] fn;
  logic [2:0] f3;
  logic [4:0] imm;
  logic       fn_ok;
  logic       f3_ok;

  assign fn       = instr[31:26];
  assign f3       = instr[14:12];
  assign imm      = instr[19:15];
  assign unmasked = instr[25];
  assign arith    = (fn == FN_ARITH);
  assign fn_ok    = (fn == FN_LOGIC) || (fn == FN_ARITH);

  always_comb begin
    f3_ok = 1'b1;
    src   = CNT_VEC;
    case (f3)
      SRC_VV:  src = CNT_VEC;
      SRC_VX:  src = CNT_SCL;
      SRC_VI:  src = CNT_IMM;
      default: f3_ok = 1'b0;
    endcase
  end

  assign legal   = (instr[6:0] == MAJOR_OP) && fn_ok && f3_ok;
  assign imm_ext = arith ? {{(XLEN-5){imm[4]}}, imm} : {{(XLEN-5){1'b0}}, imm};
endmodule

// File: rtl/vss_lane.sv
module vss_lane
  import vss_pkg::*;
#(
  parameter int W  = 8,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] cnt,
  input  logic          arith,
  input  logic [1:0]    rm,
  output logic [W-1:0]  res
);
  logic [W-1:0] shifted;
  logic [W-1:0] out_bits;
  logic [W-1:0] half_bit;
  logic         d_bit;
  logic         low_any;
  logic         all_any;
  logic         inc;

  assign shifted  = arith ? W'($signed(a) >>> cnt) : (a >> cnt);
  assign out_bits = (W'(1) << cnt) - W'(1);
  assign half_bit = (W'(1) << cnt) >> 1;
  assign d_bit    = |(a & half_bit);
  assign low_any  = |(a & (half_bit - W'(1)) & out_bits);
  assign all_any  = |(a & out_bits);

  always_comb begin
    case (rmode_e'(rm))
      RM_HALF_UP: inc = d_bit;
      RM_EVEN:    inc = d_bit & (low_any | shifted[0]);
      RM_TRUNC:   inc = 1'b0;
      default:    inc = ~shifted[0] & all_any;
    endcase
  end

  assign res = shifted + W'(inc);

  always_comb begin
    if (cnt == '0) begin
      // R8
      zero_shift_chk: assert (res == a);
    end
  end
endmodule

// File: rtl/vss_width_slice.sv
module vss_width_slice
  import vss_pkg::*;
#(
  parameter int EW     = 8,
  parameter int DATA_W = 64,
  parameter int XLEN   = 64,
  localparam int NL    = DATA_W / EW,
  localparam int SW    = $clog2(EW)
) (
  input  logic [DATA_W-1:0]   vs2,
  input  logic [DATA_W-1:0]   vs1,
  input  logic [XLEN-1:0]     scalar,
  input  logic [XLEN-1:0]     imm_ext,
  input  cnt_src_e            src,
  input  logic                arith,
  input  logic [1:0]          rm,
  input  logic                unmasked,
  input  logic [DATA_W/8-1:0] mask,
  output logic [DATA_W-1:0]   res,
  output logic [DATA_W-1:0]   wen
);
  for (genvar i = 0; i < NL; i++) begin : g_lane
    logic [SW-1:0] cnt;

    always_comb begin
      case (src)
        CNT_VEC: cnt = vs1[i*EW +: SW];
        CNT_SCL: cnt = scalar[SW-1:0];
        default: cnt = imm_ext[SW-1:0];
      endcase
    end

    vss_lane #(.W(EW)) u_lane (
      .a     (vs2[i*EW +: EW]),
      .cnt   (cnt),
      .arith (arith),
      .rm    (rm),
      .res   (res[i*EW +: EW])
    );

    assign wen[i*EW +: EW] = {EW{unmasked | mask[i]}};
  end
endmodule

// File: rtl/vscale_shift.sv
module vscale_shift
  import vss_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int XLEN   = 64,
  localparam int MW    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        sew,
  input  logic [1:0]        rnd_mode,
  input  logic [DATA_W-1:0] vs2_data,
  input  logic [DATA_W-1:0] vs1_data,
  input  logic [XLEN-1:0]   scalar,
  input  logic [MW-1:0]     mask,
  input  logic [DATA_W-1:0] old_dest,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic            legal;
  logic            arith;
  logic            unmasked;
  cnt_src_e        src;
  logic [XLEN-1:0] imm_ext;
  logic            accept;

  logic [DATA_W-1:0] w_res [4];
  logic [DATA_W-1:0] w_en  [4];
  logic [DATA_W-1:0] merged;

  vss_decode #(.XLEN(XLEN)) u_dec (
    .instr    (instr),
    .legal    (legal),
    .arith    (arith),
    .unmasked (unmasked),
    .src      (src),
    .imm_ext  (imm_ext)
  );

  for (genvar k = 0; k < 4; k++) begin : g_width
    if ((8 << k) <= DATA_W) begin : g_on
      vss_width_slice #(.EW(8 << k), .DATA_W(DATA_W), .XLEN(XLEN)) u_slice (
        .vs2      (vs2_data),
        .vs1      (vs1_data),
        .scalar   (scalar),
        .imm_ext  (imm_ext),
        .src      (src),
        .arith    (arith),
        .rm       (rnd_mode),
        .unmasked (unmasked),
        .mask     (mask),
        .res      (w_res[k]),
        .wen      (w_en[k])
      );
    end else begin : g_off
      assign w_res[k] = '0;
      assign w_en[k]  = '0;
    end
  end

  assign merged = (w_res[sew] & w_en[sew]) | (old_dest & ~w_en[sew]);
  assign accept = in_valid && legal;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= accept;
      if (accept) result <= merged;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // R12
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !legal) |=> (!out_valid && $stable(result)));

  // R10
  mask_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !instr[25] && mask == '0) |=> (result == $past(old_dest)));
endmodule

// File: tb/vscale_shift_bench.sv
module vscale_shift_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0]  sew = '0;
  logic [1:0]  rnd_mode = '0;
  logic [63:0] vs2_data = '0;
  logic [63:0] vs1_data = '0;
  logic [63:0] scalar = '0;
  logic [7:0]  mask = '0;
  logic [63:0] old_dest = '0;
  logic        out_valid;
  logic [63:0] result;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vscale_shift u_vscale_shift (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .sew(sew),
    .rnd_mode(rnd_mode), .vs2_data(vs2_data), .vs1_data(vs1_data),
    .scalar(scalar), .mask(mask), .old_dest(old_dest),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] enc(logic [5:0] f6, logic vm, logic [4:0] imm, logic [2:0] f3);
    return {f6, vm, 5'd2, imm, f3, 5'd3, 7'b1010111};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [1:0]  sw;
    logic [1:0]  rm;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] s;
    logic [7:0]  m;
    logic [63:0] old;
    logic [63:0] exp;
  } vec_t;

  localparam vec_t TBL [11] = '{
    // R7 mode 00, R5 scalar source
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd0, 64'h0C0C0C0C0C0C0C0C, 64'd0, 64'd3, 8'h00, 64'd0, 64'h0202020202020202},
    // R7 mode 10
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd2, 64'h0C0C0C0C0C0C0C0C, 64'd0, 64'd3, 8'h00, 64'd0, 64'h0101010101010101},
    // R7 mode 01
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd1, 64'h0C040C040C040C04, 64'd0, 64'd3, 8'h00, 64'd0, 64'h0200020002000200},
    // R7 mode 11
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd3, 64'h0C040C040C040C04, 64'd0, 64'd3, 8'h00, 64'd0, 64'h0101010101010101},
    // R4 sign fill, R9 wrap
    '{enc(6'b101011,1'b1,5'd0,3'b100), 2'd0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 64'd0, 64'd1, 8'h00, 64'd0, 64'h0000000000000000},
    // R4 zero fill
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 64'd0, 64'd1, 8'h00, 64'd0, 64'h8080808080808080},
    // R6 zero-extended immediate
    '{enc(6'b101010,1'b1,5'b10000,3'b011), 2'd3, 2'd2, 64'h8000000000000000, 64'd0, 64'd0, 8'h00, 64'd0, 64'h0000800000000000},
    // R6 sign-extended immediate
    '{enc(6'b101011,1'b1,5'b10000,3'b011), 2'd3, 2'd2, 64'h8000000000000000, 64'd0, 64'd0, 8'h00, 64'd0, 64'hFFFFFFFFFFFF8000},
    // R3 R2 vector counts with high bit set, 16-bit lanes
    '{enc(6'b101010,1'b1,5'd0,3'b000), 2'd1, 2'd0, 64'h0003000300030003, 64'h0011001100110011, 64'd0, 8'h00, 64'd0, 64'h0002000200020002},
    // R10 R8 masked lanes, zero shift
    '{enc(6'b101010,1'b0,5'd0,3'b100), 2'd0, 2'd0, 64'h1111111111111111, 64'd0, 64'd0, 8'h55, 64'hAAAAAAAAAAAAAAAA, 64'hAA11AA11AA11AA11},
    // R3 scalar high bits ignored
    '{enc(6'b101010,1'b1,5'd0,3'b100), 2'd0, 2'd2, 64'h0C0C0C0C0C0C0C0C, 64'd0, 64'hFFFFFFFF000000FB, 8'h00, 64'd0, 64'h0101010101010101}
  };

  function automatic logic [63:0] ref_word(logic [31:0] ins, logic [1:0] sw, logic [1:0] rm,
      logic [63:0] va, logic [63:0] vb, logic [63:0] s, logic [7:0] m, logic [63:0] old);
    int w = 8 << sw;
    int n = 64 / w;
    logic [63:0] lm = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] acc = '0;
    logic ar = ins[26];
    for (int i = 0; i < n; i++) begin
      logic [63:0] a, amt, r, sa;
      int sh;
      logic d, lo, any, inc;
      a = (va >> (i * w)) & lm;
      case (ins[14:12])
        3'b000:  amt = (vb >> (i * w)) & lm;
        3'b100:  amt = s;
        default: amt = ar ? {{59{ins[19]}}, ins[19:15]} : {59'd0, ins[19:15]};
      endcase
      sh = int'(amt & 64'(w - 1));
      if (ar) begin
        sa = a[w-1] ? (a | ~lm) : a;
        r = 64'($signed(sa) >>> sh) & lm;
      end else begin
        r = a >> sh;
      end
      any = (sh > 0) ? |(a & ((64'd1 << sh) - 64'd1)) : 1'b0;
      d   = (sh > 0) ? a[sh-1] : 1'b0;
      lo  = (sh > 1) ? |(a & ((64'd1 << (sh - 1)) - 64'd1)) : 1'b0;
      case (rm)
        2'd0: inc = d;
        2'd1: inc = d & (lo | r[0]);
        2'd2: inc = 1'b0;
        default: inc = ~r[0] & any;
      endcase
      r = (r + 64'(inc)) & lm;
      if (!ins[25] && !m[i]) r = (old >> (i * w)) & lm;
      acc = acc | (r << (i * w));
    end
    return acc;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] ins, logic [1:0] sw, logic [1:0] rm, logic [63:0] a,
      logic [63:0] b, logic [63:0] s, logic [7:0] m, logic [63:0] old);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; sew = sw; rnd_mode = rm;
    vs2_data = a; vs1_data = b; scalar = s; mask = m; old_dest = old;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] prev;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", {63'd0, out_valid}, 64'd0);
    check("R1 result", result, 64'd0);
    rst = 1'b0;

    for (int t = 0; t < 11; t++) begin
      apply(TBL[t].ins, TBL[t].sw, TBL[t].rm, TBL[t].a, TBL[t].b, TBL[t].s, TBL[t].m, TBL[t].old);
      check("R2-table valid R12", {63'd0, out_valid}, 64'd1);
      check("R7 table", result, TBL[t].exp);
    end

    // R11 illegal major opcode: result held, valid low
    prev = result;
    apply(TBL[0].ins ^ 32'h1, 2'd0, 2'd0, 64'h1234, 64'd0, 64'd0, 8'h00, 64'd0);
    check("R11 valid", {63'd0, out_valid}, 64'd0);
    check("R11 hold", result, prev);
    // R11 illegal source code
    apply({TBL[0].ins[31:15], 3'b001, TBL[0].ins[11:0]}, 2'd0, 2'd0, 64'h1234, 64'd0, 64'd0, 8'h00, 64'd0);
    check("R11 source", result, prev);
    // R12 idle cycle clears valid
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R12 idle", {63'd0, out_valid}, 64'd0);

    // R7 R2 R8 random sweep with boundary counts
    for (int t = 0; t < 600; t++) begin
      logic [31:0] ins;
      logic [1:0] sw, rm;
      logic [63:0] a, b, s, old;
      logic [7:0] m;
      logic [2:0] f3;
      int w;
      sw = 2'(t % 4);
      rm = 2'((t / 4) % 4);
      w  = 8 << sw;
      case ((t / 16) % 3)
        0: f3 = 3'b000;
        1: f3 = 3'b100;
        default: f3 = 3'b011;
      endcase
      ins = enc(($urandom % 2) ? 6'b101011 : 6'b101010, 1'($urandom), 5'($urandom), f3);
      a   = {$urandom, $urandom};
      b   = {$urandom, $urandom};
      s   = {$urandom, $urandom};
      old = {$urandom, $urandom};
      m   = 8'($urandom);
      if (t % 5 == 0) s = 64'(w - 1);
      if (t % 7 == 0) s = 64'd0;
      apply(ins, sw, rm, a, b, s, m, old);
      check("R7 random", result, ref_word(ins, sw, rm, a, b, s, m, old));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule